// File: doc/BRIEF.md
# Paged Memory Map Decoder

This block turns a 16-bit CPU address into one chip select for one of four kinds of target. The lower half of the map is flat RAM, except for its last 256-byte page, which is the I/O page. Above that sit sixteen 1 KB windows onto a 256 KB banked SRAM, and the top 16 KB is ROM. The high address byte is compared against the I/O page number. The result is "below", "equal" or "above", and it picks RAM, I/O or the upper space. On "equal", the middle nibble of the address picks one of sixteen 16-byte device slots.

Each window has its own 8-bit bank register. When a window is addressed, the banked SRAM address is that window's bank value with CPU address bits 9:0 appended below it. The bank registers live in I/O slot 0, one byte per window. They are written with an ordinary bus write and read back through a dedicated read-data output. Two windows may hold the same bank value, and the same SRAM bank then shows up at both addresses. The decode itself is purely combinational. Only the bank registers hold state.

Top module: `paged_map_decoder`

## Requirements
- R1: Addresses 0x0000 to 0x7EFF assert `cs_ram` and no other select.
- R2: Addresses 0x7F00 to 0x7FFF assert exactly one bit of `cs_io`, the bit whose index is address bits 7:4.
- R3: Addresses 0x8000 to 0xBFFF assert `cs_win`. `sram_addr` is the bank register of window number address bits 13:10, followed by address bits 9:0. Outside this range `sram_addr` is zero.
- R4: Addresses 0xC000 to 0xFFFF assert `cs_rom`, and `mem_we` stays low there even when `bus_wr` is high.
- R5: For every address, exactly one of `cs_ram`, the sixteen `cs_io` bits, `cs_win` and `cs_rom` is high.
- R6: After reset, bank register n holds the value n for n = 0..15, so the windows map SRAM linearly.
- R7: A write (`bus_wr` high) to 0x7F00+n, with n in 0..15, loads `bus_wdata` into bank register n at the next rising clock edge. While the address is 0x7F00+n, `reg_rdata` shows bank register n. At every other address `reg_rdata` is zero.
- R8: Writes to any address outside 0x7F00 to 0x7F0F leave every bank register unchanged.
- R9: Two windows that hold the same bank value produce the same `sram_addr` for the same offset.
- R10: `mem_we` equals `bus_wr` for every address outside ROM.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | CPU address |
| bus_wr | input | 1 | Write strobe for the current address |
| bus_wdata | input | 8 | CPU write data |
| cs_ram | output | 1 | Flat RAM select |
| cs_io | output | 16 | One-hot I/O device slot selects |
| cs_win | output | 1 | Banked SRAM select |
| cs_rom | output | 1 | ROM select |
| mem_we | output | 1 | Write enable toward the selected target, held low for ROM |
| sram_addr | output | 18 | Banked SRAM address |
| reg_rdata | output | 8 | Bank register read data for slot 0, zero elsewhere |

## Verification
Every select, `sram_addr`, `mem_we` and `reg_rdata` follows `bus_addr` in the same cycle, with no register in the path. The only delayed effect is a bank register write, which shows up after the first rising edge that sees the strobe. The bench changes the address on the falling edge and samples 2 ns later, before the next rising edge. Register read-back is sampled only once the falling edge after the write edge has passed. The whole address space is swept both with reset bank values and with rewritten ones, and each result is compared with values computed from the address arithmetic.

// File: rtl/pmd_pkg.sv
package pmd_pkg;
    typedef enum logic [1:0] {
        RGN_RAM = 2'd0,
        RGN_IO  = 2'd1,
        RGN_WIN = 2'd2,
        RGN_ROM = 2'd3
    } region_e;
endpackage

// File: rtl/pmd_cmp3.sv
module pmd_cmp3 #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic         lt,
    output logic         eq,
    output logic         gt
);
    always_comb begin
        lt = (a < b);
        eq = (a == b);
        gt = (a > b);
    end
endmodule

// File: rtl/pmd_slot_dec.sv
module pmd_slot_dec #(
    parameter int SEL_W = 4,
    localparam int N    = 1 << SEL_W
) (
    input  logic             en,
    input  logic [SEL_W-1:0] sel,
    output logic [N-1:0]     onehot
);
    for (genvar g = 0; g < N; g++) begin : g_slot
        assign onehot[g] = en && (sel == SEL_W'(g));
    end
endmodule

// File: rtl/pmd_bank_regs.sv
module pmd_bank_regs #(
    parameter int WIN_CNT = 16,
    parameter int BANK_W  = 8,
    localparam int IDX_W  = $clog2(WIN_CNT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [BANK_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [BANK_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  win_idx,
    output logic [BANK_W-1:0] win_bank
);
    typedef struct packed {
        logic [WIN_CNT-1:0][BANK_W-1:0] bank;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bank[wr_idx] = wr_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WIN_CNT; i++) begin
                st_q.bank[i] <= BANK_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data  = st_q.bank[rd_idx];
    assign win_bank = st_q.bank[win_idx];
endmodule

// File: rtl/paged_map_decoder.sv
module paged_map_decoder #(
    parameter int ADDR_W  = 16,
    parameter int HI_W    = 8,
    parameter int DATA_W  = 8,
    parameter int SLOT_CNT = 16,
    parameter int WIN_CNT = 16,
    parameter int WIN_AW  = 10,
    parameter logic [HI_W-1:0] IO_PAGE = 8'h7F,
    localparam int LO_W      = ADDR_W - HI_W,
    localparam int SLOT_SEL_W = $clog2(SLOT_CNT),
    localparam int WIN_IDX_W = $clog2(WIN_CNT),
    localparam int SRAM_AW   = DATA_W + WIN_AW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic                cs_ram,
    output logic [SLOT_CNT-1:0] cs_io,
    output logic                cs_win,
    output logic                cs_rom,
    output logic                mem_we,
    output logic [SRAM_AW-1:0]  sram_addr,
    output logic [DATA_W-1:0]   reg_rdata
);
    import pmd_pkg::*;

    localparam int WIN_BASE_I = (int'(IO_PAGE) + 1) << LO_W;
    localparam int ROM_BASE_I = WIN_BASE_I + WIN_CNT * (1 << WIN_AW);

    typedef struct packed {
        region_e             rgn;
        logic                we;
        logic                reg_wr;
        logic [SRAM_AW-1:0]  sram;
        logic [DATA_W-1:0]   rdata;
    } dec_t;

    logic                  hi_lt, hi_eq, hi_gt;
    logic [SLOT_CNT-1:0]   slot_sel;
    logic [ADDR_W-1:0]     win_off;
    logic [WIN_IDX_W-1:0]  win_idx;
    logic [WIN_IDX_W-1:0]  reg_idx;
    logic [DATA_W-1:0]     reg_val;
    logic [DATA_W-1:0]     win_bank;
    logic                  slot0_hit;
    dec_t                  dec_d;

    pmd_cmp3 #(.W(HI_W)) u_cmp (
        .a  (bus_addr[ADDR_W-1 -: HI_W]),
        .b  (IO_PAGE),
        .lt (hi_lt),
        .eq (hi_eq),
        .gt (hi_gt)
    );

    pmd_slot_dec #(.SEL_W(SLOT_SEL_W)) u_slots (
        .en     (hi_eq),
        .sel    (bus_addr[LO_W-1 -: SLOT_SEL_W]),
        .onehot (slot_sel)
    );

    assign win_off   = bus_addr - ADDR_W'(WIN_BASE_I);
    assign win_idx   = WIN_IDX_W'(win_off >> WIN_AW);
    assign reg_idx   = bus_addr[WIN_IDX_W-1:0];
    assign slot0_hit = slot_sel[0];

    pmd_bank_regs #(.WIN_CNT(WIN_CNT), .BANK_W(DATA_W)) u_banks (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (dec_d.reg_wr),
        .wr_idx   (reg_idx),
        .wr_data  (bus_wdata),
        .rd_idx   (reg_idx),
        .rd_data  (reg_val),
        .win_idx  (win_idx),
        .win_bank (win_bank)
    );

    always_comb begin
        dec_d = '0;
        if (hi_lt) begin
            dec_d.rgn = RGN_RAM;
        end else if (hi_eq) begin
            dec_d.rgn = RGN_IO;
        end else if ({1'b0, bus_addr} >= (ADDR_W+1)'(ROM_BASE_I)) begin
            dec_d.rgn = RGN_ROM;
        end else begin
            dec_d.rgn = RGN_WIN;
        end
        dec_d.we     = bus_wr && (dec_d.rgn != RGN_ROM);
        dec_d.reg_wr = bus_wr && slot0_hit;
        if (dec_d.rgn == RGN_WIN) begin
            dec_d.sram = {win_bank, bus_addr[WIN_AW-1:0]};
        end
        if (slot0_hit) begin
            dec_d.rdata = reg_val;
        end
    end

    assign cs_ram    = (dec_d.rgn == RGN_RAM);
    assign cs_io     = slot_sel;
    assign cs_win    = (dec_d.rgn == RGN_WIN);
    assign cs_rom    = (dec_d.rgn == RGN_ROM);
    assign mem_we    = dec_d.we;
    assign sram_addr = dec_d.sram;
    assign reg_rdata = dec_d.rdata;
endmodule

// File: rtl/paged_map_decoder_chk.sv
module paged_map_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] bus_addr,
    input logic        bus_wr,
    input logic [7:0]  bus_wdata,
    input logic        cs_ram,
    input logic [15:0] cs_io,
    input logic        cs_win,
    input logic        cs_rom,
    input logic        mem_we,
    input logic [17:0] sram_addr,
    input logic [7:0]  reg_rdata
);
    // R5
    a_r5_one_select: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({cs_ram, cs_io, cs_win, cs_rom}) == 1);

    // R4
    a_r4_rom_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        cs_rom |-> !mem_we);

    // R2
    a_r2_slot_matches_nibble: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_io != 16'h0) |-> cs_io[bus_addr[7:4]]);

    // R3
    a_r3_offset_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        cs_win |-> (sram_addr[9:0] == bus_addr[9:0]));

    // R7
    a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[15:4] == 12'h7F0) |=>
        ((bus_addr != $past(bus_addr)) || (reg_rdata == $past(bus_wdata))));

    // R10
    a_r10_we_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_rom |-> (mem_we == bus_wr));
endmodule

bind paged_map_decoder paged_map_decoder_chk u_chk (.*);

// File: tb/paged_map_decoder_test.sv
`timescale 1ns/1ps
module paged_map_decoder_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = 8'h0;
    logic        cs_ram;
    logic [15:0] cs_io;
    logic        cs_win;
    logic        cs_rom;
    logic        mem_we;
    logic [17:0] sram_addr;
    logic [7:0]  reg_rdata;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;
    logic [7:0] exp_bank [16];

    always #4 clk = ~clk;

    paged_map_decoder uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .cs_ram(cs_ram), .cs_io(cs_io), .cs_win(cs_win),
        .cs_rom(cs_rom), .mem_we(mem_we), .sram_addr(sram_addr), .reg_rdata(reg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s addr=%h actual=%h expected=%h", req, bus_addr, act, exp);
        end
    endtask

    task automatic check_addr(input logic [15:0] a, input logic wr);
        logic e_ram, e_win, e_rom, e_we, io;
        logic [15:0] e_io;
        logic [17:0] e_sram;
        logic [7:0]  e_rd;
        e_ram  = (a < 16'h7F00);
        io     = (a[15:8] == 8'h7F);
        e_win  = (a >= 16'h8000) && (a < 16'hC000);
        e_rom  = (a >= 16'hC000);
        e_io   = io ? (16'h1 << a[7:4]) : 16'h0;
        e_sram = e_win ? {exp_bank[a[13:10]], a[9:0]} : 18'h0;
        e_rd   = (io && a[7:4] == 4'h0) ? exp_bank[a[3:0]] : 8'h0;
        e_we   = wr && !e_rom;
        chk(cs_ram == e_ram, "R1", 32'(cs_ram), 32'(e_ram));
        chk(cs_io == e_io, "R2", 32'(cs_io), 32'(e_io));
        chk(cs_win == e_win && sram_addr == e_sram, "R3", 32'(sram_addr), 32'(e_sram));
        chk(cs_rom == e_rom, "R4", 32'(cs_rom), 32'(e_rom));
        chk($countones({cs_ram, cs_io, cs_win, cs_rom}) == 1, "R5",
            32'($countones({cs_ram, cs_io, cs_win, cs_rom})), 32'd1);
        chk(reg_rdata == e_rd, "R7", 32'(reg_rdata), 32'(e_rd));
        chk(mem_we == e_we, "R10", 32'(mem_we), 32'(e_we));
    endtask

    task automatic probe(input logic [15:0] a);
        @(negedge clk);
        bus_addr = a;
        bus_wr   = 1'b0;
        #2;
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        bus_addr  = a;
        bus_wdata = v;
        bus_wr    = 1'b1;
        #2;
        check_addr(a, 1'b1);
        @(negedge clk);
        bus_wr = 1'b0;
        if (a[15:4] == 12'h7F0) exp_bank[a[3:0]] = v;
    endtask

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        if (!finished) begin
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 16; i++) exp_bank[i] = 8'(i);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R6: reset bank values read back through slot 0
        for (int i = 0; i < 16; i++) begin
            probe(16'h7F00 | 16'(i));
            chk(reg_rdata == 8'(i), "R6", 32'(reg_rdata), 32'(i));
        end

        // R1..R5, R7, R10: full sweep with reset banks
        for (int a = 0; a < 65536; a++) begin
            probe(16'(a));
            check_addr(16'(a), 1'b0);
        end

        // R7: rewrite every bank register
        for (int i = 0; i < 16; i++) bus_write(16'h7F00 | 16'(i), 8'((i * 37 + 5) ^ 8'hA0));
        for (int i = 0; i < 16; i++) begin
            probe(16'h7F00 | 16'(i));
            chk(reg_rdata == exp_bank[i], "R7", 32'(reg_rdata), 32'(exp_bank[i]));
        end

        // R3: window sweep with new banks
        for (int a = 16'h8000; a < 16'hC000; a++) begin
            probe(16'(a));
            check_addr(16'(a), 1'b0);
        end

        // R8 and R10/R4: writes outside slot 0 touch no bank register
        bus_write(16'h7F13, 8'hEE);
        bus_write(16'h0003, 8'hEE);
        bus_write(16'h7EFF, 8'hEE);
        bus_write(16'h8C03, 8'hEE);
        bus_write(16'hE003, 8'hEE);
        bus_write(16'hFFFF, 8'hEE);
        for (int i = 0; i < 16; i++) begin
            probe(16'h7F00 | 16'(i));
            chk(reg_rdata == exp_bank[i], "R8", 32'(reg_rdata), 32'(exp_bank[i]));
        end

        // R9: two windows sharing one bank
        bus_write(16'h7F02, 8'h5A);
        bus_write(16'h7F0B, 8'h5A);
        for (int off = 0; off < 1024; off += 97) begin
            logic [17:0] s_lo;
            probe(16'h8800 + 16'(off));
            s_lo = sram_addr;
            probe(16'hAC00 + 16'(off));
            chk(sram_addr == s_lo && s_lo == {8'h5A, 10'(off)}, "R9",
                32'(sram_addr), 32'({8'h5A, 10'(off)}));
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule